// File: doc/BRIEF.md
# Buffered Flash Page Program Engine

This block sends a flash page-program command on a single-lane SPI link. It has two modes. In buffered mode it sends a full page of 128 data bytes from an internal word buffer. In unbuffered mode it sends a single data byte. Software drives the block through a small register port. It loads the program opcode and a 3- or 4-byte target address. It selects buffered or unbuffered operation and then sets a trigger bit. The engine drives chip select, serial clock and the data line until the frame is complete. It then clears the trigger bit.

In buffered mode the page arrives as 32 little-endian 32-bit words through one port register. Each word write appends one buffer entry. Setting or clearing buffered mode does not take effect at once. The engine applies the change a few cycles later, and only while it is idle. Software sees the change only when the mode bit reads back with its new value. The fill count of the buffer can be read at the word port. It returns to zero after each buffered program completes.

Top module: `ppe_engine`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, and reads of the control register (0x0), the mode register (0x1) and the word port (0x8) all return 0.
- R2: Bit 0 of the mode register (0x1) requests buffered mode. A read of that bit returns the applied state. The applied state follows a new request only after `ACK_CYC` idle cycles, so a read in the cycle right after the write still shows the old value.
- R3: Each word written to the word port (0x8) supplies four page bytes. Bits 7:0 are sent first and bits 31:24 last. Words are sent in the order they were written.
- R4: A buffered program sends the opcode (register 0x2, bits 7:0), then the address, then exactly 128 page bytes, with `spi_cs_n` held low for the whole frame.
- R5: The address is sent most significant byte first. It is formed from address byte registers 0x3 (least significant) to 0x5 when bit 1 of the mode register is 0. With that bit set, register 0x6 is added as the most significant byte, giving 4 address bytes.
- R6: In unbuffered mode the frame is the opcode, the address and exactly one data byte taken from bits 7:0 of register 0x7.
- R7: Writing 1 to bit 4 of the control register (0x0) starts a frame. Bit 4 reads 1 while the frame runs and clears when `spi_cs_n` returns high.
- R8: In buffered mode, a trigger issued while fewer than 32 words are loaded is ignored: no frame starts and bit 4 reads 0.
- R9: A read of the word port returns the fill count, which never exceeds 32. Word writes beyond 32 are ignored. The count returns to 0 after a buffered program completes.
- R10: The link uses SPI mode 0. `spi_mosi` does not change at a rising edge of `spi_sclk`, and `spi_sclk` is low whenever `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |

## Verification
A wrong write pointer or fill count shows at the word port on the next read. It also shows as a frame with shifted or repeated page bytes, or as a trigger that is wrongly ignored or wrongly accepted. A byte-index or lane-select fault shows in the decoded serial byte stream within one byte time of where it occurs. An early or missing mode apply shows in the mode read-back on the cycle after the write. A broken end-of-frame sequence shows as a trigger bit that never clears, or as chip select rising more than once per frame.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] RA_CTRL  = 4'h0;
  localparam logic [REG_AW-1:0] RA_MODE  = 4'h1;
  localparam logic [REG_AW-1:0] RA_OPC   = 4'h2;
  localparam logic [REG_AW-1:0] RA_ADR0  = 4'h3;
  localparam logic [REG_AW-1:0] RA_WBYTE = 4'h7;
  localparam logic [REG_AW-1:0] RA_PORT  = 4'h8;
  localparam int TRIG_BIT = 4;
  localparam int ADDR_BYTES_MAX = 4;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_FETCH,
    SH_SHIFT,
    SH_DONE
  } sh_state_t;
endpackage

// File: rtl/ppe_regs.sv
module ppe_regs
  import ppe_pkg::*;
#(
  parameter int PAGE_WORDS = 32,
  parameter int ACK_CYC    = 4,
  localparam int FILL_W    = $clog2(PAGE_WORDS + 1),
  localparam int ACK_W     = $clog2(ACK_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic [FILL_W-1:0] fill_cnt,
  output logic [7:0]        opcode,
  output logic [31:0]       addr,
  output logic [7:0]        wbyte,
  output logic              addr4,
  output logic              mode_applied,
  output logic              start,
  output logic              word_we
);
  logic             mode_req;
  logic [ACK_W-1:0] ack_cnt;
  logic [7:0]       adr_b [ADDR_BYTES_MAX];

  // Address byte registers, one per byte lane
  for (genvar i = 0; i < ADDR_BYTES_MAX; i++) begin : g_adr
    always_ff @(posedge clk) begin
      if (rst) begin
        adr_b[i] <= '0;
      end else if (reg_wr && reg_addr == RA_ADR0 + REG_AW'(i)) begin
        adr_b[i] <= reg_wdata[7:0];
      end
    end
    assign addr[8*i +: 8] = adr_b[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode <= '0;
      wbyte  <= '0;
      addr4  <= 1'b0;
      mode_req <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == RA_OPC)   opcode <= reg_wdata[7:0];
      if (reg_addr == RA_WBYTE) wbyte  <= reg_wdata[7:0];
      if (reg_addr == RA_MODE) begin
        mode_req <= reg_wdata[0];
        addr4    <= reg_wdata[1];
      end
    end
  end

  // Buffer-mode change is applied after ACK_CYC idle cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_applied <= 1'b0;
      ack_cnt      <= '0;
    end else if (mode_req != mode_applied && !busy) begin
      if (ack_cnt == ACK_W'(ACK_CYC - 1)) begin
        mode_applied <= mode_req;
        ack_cnt      <= '0;
      end else begin
        ack_cnt <= ack_cnt + 1'b1;
      end
    end else begin
      ack_cnt <= '0;
    end
  end

  assign word_we = reg_wr && reg_addr == RA_PORT;
  assign start = reg_wr && reg_addr == RA_CTRL && reg_wdata[TRIG_BIT] && !busy &&
                 (!mode_applied || fill_cnt == FILL_W'(PAGE_WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_CTRL:  reg_rdata <= 32'(busy) << TRIG_BIT;
        RA_MODE:  reg_rdata <= {30'd0, addr4, mode_applied};
        RA_OPC:   reg_rdata <= {24'd0, opcode};
        RA_WBYTE: reg_rdata <= {24'd0, wbyte};
        RA_PORT:  reg_rdata <= 32'(fill_cnt);
        default: begin
          if (reg_addr >= RA_ADR0 && reg_addr < RA_ADR0 + REG_AW'(ADDR_BYTES_MAX))
            reg_rdata <= {24'd0, adr_b[2'(reg_addr - RA_ADR0)]};
          else
            reg_rdata <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ppe_pagebuf.sv
module ppe_pagebuf #(
  parameter int PAGE_WORDS = 32,
  localparam int AW        = $clog2(PAGE_WORDS),
  localparam int FILL_W    = $clog2(PAGE_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              clr,
  input  logic [AW-1:0]     raddr,
  output logic [31:0]       q,
  output logic [FILL_W-1:0] fill
);
  logic [31:0] mem [PAGE_WORDS];
  logic        accept;

  assign accept = we && !busy && fill < FILL_W'(PAGE_WORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
    end else if (clr) begin
      fill <= '0;
    end else if (accept) begin
      fill <= fill + 1'b1;
    end
  end

  // Memory without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (accept) mem[AW'(fill)] <= wdata;
  end

  always_ff @(posedge clk) begin
    q <= mem[raddr];
  end
endmodule

// File: rtl/ppe_shifter.sv
module ppe_shifter
  import ppe_pkg::*;
#(
  parameter int SCK_HALF   = 2,
  parameter int PAGE_WORDS = 32,
  localparam int AW        = $clog2(PAGE_WORDS),
  localparam int PAGE_BYTES = 4 * PAGE_WORDS,
  localparam int IDX_W     = $clog2(PAGE_BYTES + ADDR_BYTES_MAX + 2),
  localparam int DIV_W     = $clog2(SCK_HALF) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_buf,
  input  logic          addr4,
  input  logic [7:0]    opcode,
  input  logic [31:0]   addr,
  input  logic [7:0]    wbyte,
  input  logic [31:0]   mem_q,
  output logic [AW-1:0] mem_raddr,
  output logic          busy,
  output logic          done_buf,
  output logic          spi_sclk,
  output logic          spi_cs_n,
  output logic          spi_mosi
);
  sh_state_t        state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] n_addr;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] data_idx;
  logic [IDX_W-1:0] adr_sel;
  logic [2:0]       bit_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [7:0]       shreg;
  logic [7:0]       cur_byte;
  logic             fetch_ph;
  logic             buf_q;
  logic             a4_q;

  assign n_addr   = a4_q ? IDX_W'(4) : IDX_W'(3);
  assign last_idx = n_addr + (buf_q ? IDX_W'(PAGE_BYTES) : IDX_W'(1));
  assign data_idx = idx - n_addr - IDX_W'(1);
  assign adr_sel  = n_addr - idx;
  assign mem_raddr = AW'(data_idx >> 2);

  always_comb begin
    if (idx == '0)
      cur_byte = opcode;
    else if (idx <= n_addr)
      cur_byte = 8'(addr >> {adr_sel, 3'b000});
    else if (buf_q)
      cur_byte = 8'(mem_q >> {data_idx[1:0], 3'b000});
    else
      cur_byte = wbyte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SH_IDLE;
      idx      <= '0;
      bit_cnt  <= '0;
      div_cnt  <= '0;
      shreg    <= '0;
      fetch_ph <= 1'b0;
      buf_q    <= 1'b0;
      a4_q     <= 1'b0;
      spi_sclk <= 1'b0;
      spi_cs_n <= 1'b1;
    end else begin
      case (state)
        SH_IDLE: begin
          if (start) begin
            buf_q    <= start_buf;
            a4_q     <= addr4;
            idx      <= '0;
            fetch_ph <= 1'b0;
            spi_cs_n <= 1'b0;
            state    <= SH_FETCH;
          end
        end
        SH_FETCH: begin
          if (!fetch_ph) begin
            fetch_ph <= 1'b1;
          end else begin
            shreg   <= cur_byte;
            div_cnt <= '0;
            bit_cnt <= '0;
            state   <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (div_cnt == DIV_W'(SCK_HALF - 1)) begin
            div_cnt <= '0;
            if (!spi_sclk) begin
              spi_sclk <= 1'b1;
            end else begin
              spi_sclk <= 1'b0;
              shreg    <= {shreg[6:0], 1'b0};
              bit_cnt  <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) begin
                if (idx == last_idx) begin
                  state <= SH_DONE;
                end else begin
                  idx      <= idx + 1'b1;
                  fetch_ph <= 1'b0;
                  state    <= SH_FETCH;
                end
              end
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: begin
          spi_cs_n <= 1'b1;
          state    <= SH_IDLE;
        end
      endcase
    end
  end

  assign busy     = state != SH_IDLE;
  assign done_buf = state == SH_DONE && buf_q;
  assign spi_mosi = shreg[7];
endmodule

// File: rtl/ppe_engine.sv
module ppe_engine
  import ppe_pkg::*;
#(
  parameter int SCK_HALF   = 2,
  parameter int PAGE_WORDS = 32,
  parameter int ACK_CYC    = 4,
  localparam int AW        = $clog2(PAGE_WORDS),
  localparam int FILL_W    = $clog2(PAGE_WORDS + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi
);
  logic              busy;
  logic              done_buf;
  logic [FILL_W-1:0] fill_cnt;
  logic [7:0]        opcode;
  logic [31:0]       addr;
  logic [7:0]        wbyte;
  logic              addr4;
  logic              mode_applied;
  logic              start;
  logic              word_we;
  logic [31:0]       mem_q;
  logic [AW-1:0]     mem_raddr;

  ppe_regs #(.PAGE_WORDS(PAGE_WORDS), .ACK_CYC(ACK_CYC)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .fill_cnt(fill_cnt), .opcode(opcode), .addr(addr),
    .wbyte(wbyte), .addr4(addr4), .mode_applied(mode_applied),
    .start(start), .word_we(word_we)
  );

  ppe_pagebuf #(.PAGE_WORDS(PAGE_WORDS)) u_buf (
    .clk(clk), .rst(rst), .we(word_we), .wdata(reg_wdata), .busy(busy),
    .clr(done_buf), .raddr(mem_raddr), .q(mem_q), .fill(fill_cnt)
  );

  ppe_shifter #(.SCK_HALF(SCK_HALF), .PAGE_WORDS(PAGE_WORDS)) u_sh (
    .clk(clk), .rst(rst), .start(start), .start_buf(mode_applied),
    .addr4(addr4), .opcode(opcode), .addr(addr), .wbyte(wbyte),
    .mem_q(mem_q), .mem_raddr(mem_raddr), .busy(busy), .done_buf(done_buf),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );
endmodule

// File: rtl/ppe_engine_chk.sv
module ppe_engine_chk #(
  parameter int PAGE_WORDS = 32,
  localparam int FILL_W    = $clog2(PAGE_WORDS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic              busy,
  input logic [FILL_W-1:0] fill_cnt,
  input logic              mode_applied
);
  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
  // R10
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> $stable(spi_mosi));
  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n);
  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= FILL_W'(PAGE_WORDS));
  // R9
  fill_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(fill_cnt));
  // R2
  mode_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_applied) |-> !$past(busy));
endmodule

bind ppe_engine ppe_engine_chk #(.PAGE_WORDS(PAGE_WORDS)) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .busy(busy), .fill_cnt(fill_cnt),
  .mode_applied(mode_applied)
);

// File: tb/tb_ppe_engine.sv
module tb_ppe_engine;
  localparam int CLK_PERIOD = 10;
  localparam int ACK_CYC = 4;
  localparam logic [3:0] A_CTRL = 4'h0, A_MODE = 4'h1, A_OPC = 4'h2,
                         A_ADR0 = 4'h3, A_WB = 4'h7, A_PORT = 4'h8;
  // vector: {addr4, opcode, address, data byte}
  localparam int NV = 3;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 8'h02, 32'h00A1B2C3, 8'h5A},
    {1'b1, 8'h12, 32'h7E654321, 8'hC3},
    {1'b0, 8'h32, 32'h00FF0001, 8'h00}
  };

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi;

  int n_chk = 0, n_err = 0;
  int rx_n = 0, bitc = 0, frames = 0;
  logic [7:0] sh = 0;
  logic [7:0] rx_buf [256];
  logic [7:0] exp_b [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  ppe_engine #(.ACK_CYC(ACK_CYC)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );

  always @(negedge spi_cs_n) begin rx_n = 0; bitc = 0; end
  always @(posedge spi_cs_n) frames++;
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      if (rx_n < 256) rx_buf[rx_n] = sh;
      rx_n++;
      bitc = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(A_CTRL, v);
      if (!v[4]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic load_addr(input logic [31:0] a);
    for (int i = 0; i < 4; i++) wr(A_ADR0 + 4'(i), {24'd0, a[8*i +: 8]});
  endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'(k * 7 + seed);
  endfunction

  task automatic cmp_frame(input int n, input string req);
    int bad = -1;
    chk(rx_n == n, req, "byte count", rx_n, n);
    for (int i = 0; i < n; i++)
      if (bad < 0 && rx_buf[i] !== exp_b[i]) bad = i;
    chk(bad < 0, req, "frame content (first bad index)", bad, -1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [31:0] v;
    int f0, nb;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n === 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sclk === 1'b0, "R1", "sclk after reset", spi_sclk, 0);
    rd(A_CTRL, v); chk(v == 0, "R1", "ctrl after reset", v, 0);
    rd(A_MODE, v); chk(v == 0, "R1", "mode after reset", v, 0);
    rd(A_PORT, v); chk(v == 0, "R1", "fill after reset", v, 0);

    // Table of unbuffered frames (R6, R5, R7)
    for (int t = 0; t < NV; t++) begin
      logic [48:0] e;
      e = VEC[t];
      wr(A_MODE, {30'd0, e[48], 1'b0});
      wr(A_OPC, {24'd0, e[47:40]});
      load_addr(e[39:8]);
      wr(A_WB, {24'd0, e[7:0]});
      f0 = frames;
      wr(A_CTRL, 32'h10);
      rd(A_CTRL, v); chk(v[4] == 1'b1, "R7", "trigger busy", v, 32'h10);
      wait_idle();
      rd(A_CTRL, v); chk(v[4] == 1'b0, "R7", "trigger cleared", v, 0);
      chk(frames == f0 + 1, "R6", "one cs frame", frames - f0, 1);
      nb = e[48] ? 4 : 3;
      exp_b[0] = e[47:40];
      for (int i = 0; i < nb; i++) exp_b[1 + i] = e[8 + 8*(nb-1-i) +: 8];
      exp_b[1 + nb] = e[7:0];
      cmp_frame(nb + 2, e[48] ? "R5" : "R6");
    end

    // R2 mode apply
    wr(A_MODE, 32'h1);
    rd(A_MODE, v); chk(v[0] == 1'b0, "R2", "mode not yet applied", v[0], 0);
    repeat (ACK_CYC + 4) @(negedge clk);
    rd(A_MODE, v); chk(v[0] == 1'b1, "R2", "mode applied", v[0], 1);

    // R8 short buffer trigger ignored
    for (int k = 0; k < 31; k++)
      wr(A_PORT, {pat(4*k+3,1), pat(4*k+2,1), pat(4*k+1,1), pat(4*k,1)});
    rd(A_PORT, v); chk(v == 31, "R9", "fill count 31", v, 31);
    f0 = frames;
    wr(A_CTRL, 32'h10);
    rd(A_CTRL, v); chk(v[4] == 1'b0, "R8", "short trigger not busy", v, 0);
    repeat (60) @(negedge clk);
    chk(frames == f0 && spi_cs_n === 1'b1, "R8", "no frame on short trigger", frames - f0, 0);

    // R9 overflow write ignored
    for (int k = 31; k < 33; k++)
      wr(A_PORT, {pat(4*k+3,1), pat(4*k+2,1), pat(4*k+1,1), pat(4*k,1)});
    rd(A_PORT, v); chk(v == 32, "R9", "fill saturates at 32", v, 32);

    // R3/R4 buffered, 3-byte address
    wr(A_OPC, 32'h02);
    load_addr(32'h00123456);
    f0 = frames;
    wr(A_CTRL, 32'h10);
    rd(A_CTRL, v); chk(v[4] == 1'b1, "R7", "buffered busy", v, 32'h10);
    wait_idle();
    chk(frames == f0 + 1, "R4", "cs low for whole page", frames - f0, 1);
    exp_b[0] = 8'h02; exp_b[1] = 8'h12; exp_b[2] = 8'h34; exp_b[3] = 8'h56;
    for (int i = 0; i < 128; i++) exp_b[4 + i] = pat(i, 1);
    cmp_frame(132, "R4");
    chk(rx_buf[4] === pat(0,1) && rx_buf[7] === pat(3,1), "R3", "lane order",
        {rx_buf[4], rx_buf[7]}, {pat(0,1), pat(3,1)});
    rd(A_PORT, v); chk(v == 0, "R9", "fill reset after program", v, 0);

    // R5 buffered, 4-byte address
    wr(A_MODE, 32'h3);
    repeat (ACK_CYC + 4) @(negedge clk);
    for (int k = 0; k < 32; k++)
      wr(A_PORT, {pat(4*k+3,9), pat(4*k+2,9), pat(4*k+1,9), pat(4*k,9)});
    wr(A_OPC, 32'h12);
    load_addr(32'h89ABCDEF);
    wr(A_CTRL, 32'h10);
    wait_idle();
    exp_b[0] = 8'h12; exp_b[1] = 8'h89; exp_b[2] = 8'hAB; exp_b[3] = 8'hCD; exp_b[4] = 8'hEF;
    for (int i = 0; i < 128; i++) exp_b[5 + i] = pat(i, 9);
    cmp_frame(133, "R5");

    // R2 clearing buffered mode
    wr(A_MODE, 32'h0);
    rd(A_MODE, v); chk(v[0] == 1'b1, "R2", "clear not yet applied", v[0], 1);
    repeat (ACK_CYC + 4) @(negedge clk);
    rd(A_MODE, v); chk(v[0] == 1'b0, "R2", "clear applied", v[0], 0);

    report();
  end
endmodule